// File: doc/BRIEF.md
# Mixed-Precision Integer Matrix Multiply-Accumulate Unit

This block is the arithmetic core of a tensor coprocessor. Each operation takes a left operand register and a right operand register, each 256 bits wide and each read as a matrix of four rows, plus an accumulator operand spread over consecutive 256-bit registers. It returns the updated accumulator. The right operand holds the rows of the transposed weight matrix. The unit wires row j of that operand to output column j, so no data is moved to do the transpose.

Two integer modes share the same operand registers. In the narrow mode each row holds eight signed bytes. The unit forms 128 byte products and sums them into sixteen 32-bit lanes. In the wide mode each row holds four signed 16-bit halves. The unit forms 64 products and sums them into sixteen 64-bit lanes. Operations enter through a valid/ready port that carries the mode bit. They leave through a valid/ready result port.

A small occupancy machine tracks the two pipeline stages. It has four states:
- PS_EMPTY: no operation in flight.
- PS_FRONT: an operation sits in the product stage only.
- PS_BACK: a result is presented and the product stage is empty.
- PS_BOTH: both stages are occupied.

When the pipe is not stalled, the machine moves as follows:
- *fill*: PS_EMPTY goes to PS_FRONT on an accepted operation.
- *stream*: PS_FRONT and PS_BOTH go to PS_BOTH when a new operation arrives.
- *drain*: PS_FRONT and PS_BOTH go to PS_BACK when no operation arrives.
- *refill*: PS_BACK goes to PS_FRONT when a new operation arrives while the result leaves.
- *empty*: PS_BACK goes to PS_EMPTY when the result leaves and no operation arrives.

The machine holds its state whenever a presented result is not taken.

Top module: `tmac_unit`

## Requirements
- R1: With `in_mode`=0, output lane (i,j) equals accumulator lane (i,j) plus the sum over k=0..7 of left element (i,k) times right element (j,k), where all elements are signed bytes.
- R2: The right operand is consumed transposed. Its row j supplies column j of the weight matrix, so right byte (j,k) multiplies left byte (i,k) into lane (i,j).
- R3: With `in_mode`=1, output lane (i,j) equals accumulator lane (i,j) plus the sum over k=0..3 of left half (i,k) times right half (j,k), where all elements are signed 16-bit values.
- R4: Elements are two's-complement signed. Each lane wraps modulo 2^32 in mode 0 and modulo 2^64 in mode 1.
- R5: Operand row r sits in bits [64r+63:64r]. Element c of that row sits in bits [64r+w·c+w-1 : 64r+w·c], where w is 8 in mode 0 and 16 in mode 1.
- R6: Lane index is 4i+j. In mode 0, lane l uses bits [32l+31:32l] of `in_acc` and `out_acc`, and `out_acc[1023:512]` is zero. In mode 1, lane l uses bits [64l+63:64l].
- R7: An operation accepted on a rising edge (`in_valid` and `in_ready` high) has its result presented (`out_valid` high) after the following rising edge, provided the output is not stalled.
- R8: While `out_ready` stays high, `in_ready` stays high, so one operation is accepted every cycle.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low. On the next cycle `out_valid` is still high and `out_acc` is unchanged.
- R10: During and right after reset, `out_valid` is low and `in_ready` is high.
- R11: Each accepted operation produces exactly one result, in order. Cycles with `in_valid` low produce nothing, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_mode | input | 1 | 0: 8-bit elements into 32-bit lanes; 1: 16-bit elements into 64-bit lanes |
| in_lhs | input | 256 | Left (activation) operand, four rows |
| in_rhs | input | 256 | Right (weight) operand, four rows of the transposed matrix |
| in_acc | input | 1024 | Accumulator operand, sixteen lanes |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Result taken this cycle |
| out_acc | output | 1024 | Updated accumulator, sixteen lanes |

## Verification
The bench builds the unit with its default parameters: 256-bit registers, four rows and four accumulator registers. This is the only shape for which both modes are defined. The byte mode is small enough to sweep completely. Every pair of signed byte values meets in a multiplier, which takes 16384 back-to-back operations, each with a random accumulator. The 16-bit mode is covered by all pairs drawn from a set of corner values, by random operands, and by hand-built overflow cases. A final phase mixes modes, random gaps and random output stalls to exercise every state of the occupancy machine.

// File: rtl/tmac_pkg.sv
package tmac_pkg;

    typedef enum logic {
        MODE_I8  = 1'b0,
        MODE_I16 = 1'b1
    } mac_mode_e;

    typedef enum logic [1:0] {
        PS_EMPTY = 2'd0,
        PS_FRONT = 2'd1,
        PS_BACK  = 2'd2,
        PS_BOTH  = 2'd3
    } pipe_state_e;

endpackage

// File: rtl/tmac_ctrl.sv
module tmac_ctrl
    import tmac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic load_front,
    output logic load_back,
    output logic out_valid
);

    pipe_state_e state_q;
    pipe_state_e state_d;
    logic        front_full;
    logic        advance;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs decoded from the state
    always_comb begin
        front_full = 1'b0;
        out_valid  = 1'b0;
        unique case (state_q)
            PS_EMPTY: begin front_full = 1'b0; out_valid = 1'b0; end
            PS_FRONT: begin front_full = 1'b1; out_valid = 1'b0; end
            PS_BACK:  begin front_full = 1'b0; out_valid = 1'b1; end
            PS_BOTH:  begin front_full = 1'b1; out_valid = 1'b1; end
        endcase
    end

    assign advance    = !(out_valid && !out_ready);
    assign in_ready   = advance;
    assign load_front = advance && in_valid;
    assign load_back  = advance && front_full;

    // transitions: fill, stream, drain, refill, empty
    always_comb begin
        state_d = state_q;
        if (advance) begin
            unique case (state_q)
                PS_EMPTY: state_d = in_valid ? PS_FRONT : PS_EMPTY;
                PS_FRONT: state_d = in_valid ? PS_BOTH  : PS_BACK;
                PS_BACK:  state_d = in_valid ? PS_FRONT : PS_EMPTY;
                PS_BOTH:  state_d = in_valid ? PS_BOTH  : PS_BACK;
            endcase
        end
    end

endmodule

// File: rtl/tmac_cell.sv
module tmac_cell
    import tmac_pkg::*;
#(
    parameter int ROW_W = 64
) (
    input  logic [ROW_W-1:0]   lhs_row,
    input  logic [ROW_W-1:0]   rhs_row,
    input  mac_mode_e          mode,
    output logic [2*ROW_W-1:0] prod
);

    localparam int N8  = ROW_W / 8;
    localparam int N16 = ROW_W / 16;

    logic [2*ROW_W-1:0] p8;
    logic [2*ROW_W-1:0] p16;

    // byte products, sign-extended to 16 bits before multiplying
    for (genvar k = 0; k < N8; k++) begin : g_b8
        assign p8[16*k +: 16] = {{8{lhs_row[8*k+7]}}, lhs_row[8*k +: 8]}
                              * {{8{rhs_row[8*k+7]}}, rhs_row[8*k +: 8]};
    end

    // half-word products, sign-extended to 32 bits
    for (genvar k = 0; k < N16; k++) begin : g_b16
        assign p16[32*k +: 32] = {{16{lhs_row[16*k+15]}}, lhs_row[16*k +: 16]}
                               * {{16{rhs_row[16*k+15]}}, rhs_row[16*k +: 16]};
    end

    assign prod = (mode == MODE_I16) ? p16 : p8;

endmodule

// File: rtl/tmac_reduce.sv
module tmac_reduce
    import tmac_pkg::*;
#(
    parameter int ROW_W  = 64,
    parameter int LANE_W = 64
) (
    input  logic [2*ROW_W-1:0] prod,
    input  logic [LANE_W-1:0]  acc_lane,
    input  mac_mode_e          mode,
    output logic [LANE_W-1:0]  sum
);

    localparam int N8     = ROW_W / 8;
    localparam int N16    = ROW_W / 16;
    localparam int HALF_W = LANE_W / 2;

    logic [HALF_W-1:0] s_narrow;
    logic [LANE_W-1:0] s_wide;

    always_comb begin
        s_narrow = acc_lane[HALF_W-1:0];
        for (int k = 0; k < N8; k++) begin
            s_narrow = s_narrow + {{(HALF_W-16){prod[16*k+15]}}, prod[16*k +: 16]};
        end
        s_wide = acc_lane;
        for (int k = 0; k < N16; k++) begin
            s_wide = s_wide + {{(LANE_W-32){prod[32*k+31]}}, prod[32*k +: 32]};
        end
    end

    assign sum = (mode == MODE_I16) ? s_wide : {{HALF_W{1'b0}}, s_narrow};

endmodule

// File: rtl/tmac_unit.sv
module tmac_unit
    import tmac_pkg::*;
#(
    parameter int REG_W    = 256,
    parameter int NROW     = 4,
    parameter int ACC_REGS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic                      in_mode,
    input  logic [REG_W-1:0]          in_lhs,
    input  logic [REG_W-1:0]          in_rhs,
    input  logic [ACC_REGS*REG_W-1:0] in_acc,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [ACC_REGS*REG_W-1:0] out_acc
);

    localparam int ROW_W    = REG_W / NROW;
    localparam int NLANE    = NROW * NROW;
    localparam int ACC_W    = ACC_REGS * REG_W;
    localparam int WIDE_W   = ACC_W / NLANE;
    localparam int NARROW_W = WIDE_W / 2;
    localparam int PROD_W   = 2 * ROW_W;

    mac_mode_e mode_in;
    mac_mode_e mode1_q;
    mac_mode_e mode2_q;
    logic      load_front;
    logic      load_back;

    logic [WIDE_W-1:0] res_w [NLANE];

    assign mode_in = mac_mode_e'(in_mode);

    tmac_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .load_front(load_front),
        .load_back (load_back),
        .out_valid (out_valid)
    );

    always_ff @(posedge clk) begin
        if (load_front) mode1_q <= mode_in;
        if (load_back)  mode2_q <= mode1_q;
    end

    for (genvar i = 0; i < NROW; i++) begin : g_row
        for (genvar j = 0; j < NROW; j++) begin : g_col
            localparam int LANE = i * NROW + j;

            logic [PROD_W-1:0] prod_d;
            logic [PROD_W-1:0] prod_q;
            logic [WIDE_W-1:0] acc_d;
            logic [WIDE_W-1:0] acc_q;
            logic [WIDE_W-1:0] sum_d;
            logic [WIDE_W-1:0] res_q;

            // right row j feeds column j: the transpose is pure wiring
            tmac_cell #(.ROW_W(ROW_W)) u_cell (
                .lhs_row(in_lhs[ROW_W*i +: ROW_W]),
                .rhs_row(in_rhs[ROW_W*j +: ROW_W]),
                .mode   (mode_in),
                .prod   (prod_d)
            );

            assign acc_d = (mode_in == MODE_I16)
                         ? in_acc[WIDE_W*LANE +: WIDE_W]
                         : {{NARROW_W{1'b0}}, in_acc[NARROW_W*LANE +: NARROW_W]};

            always_ff @(posedge clk) begin
                if (load_front) begin
                    prod_q <= prod_d;
                    acc_q  <= acc_d;
                end
            end

            tmac_reduce #(.ROW_W(ROW_W), .LANE_W(WIDE_W)) u_reduce (
                .prod    (prod_q),
                .acc_lane(acc_q),
                .mode    (mode1_q),
                .sum     (sum_d)
            );

            always_ff @(posedge clk) begin
                if (load_back) res_q <= sum_d;
            end

            assign res_w[LANE] = res_q;
        end
    end

    always_comb begin
        out_acc = '0;
        for (int l = 0; l < NLANE; l++) begin
            if (mode2_q == MODE_I16) begin
                out_acc[WIDE_W*l +: WIDE_W] = res_w[l];
            end else begin
                out_acc[NARROW_W*l +: NARROW_W] = res_w[l][NARROW_W-1:0];
            end
        end
    end

endmodule

// File: rtl/tmac_checker.sv
module tmac_checker #(
    parameter int ACC_W = 1024
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_mode,
    input logic             out_valid,
    input logic             out_ready,
    input logic [ACC_W-1:0] out_acc
);

    // R9: a refused result stays put
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_acc)));

    // R9: a stalled output blocks intake
    p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R7: accepted work shows up one edge later when the output moves
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) ##1 (!out_valid || out_ready) |=> out_valid);

    // R11: a fresh result always traces back to an accepted operation
    p_origin_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready, 2));

    // R6: byte-mode results leave the upper accumulator half cleared
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_valid) && ($past(in_mode, 2) == 1'b0))
            |-> (out_acc[ACC_W-1:ACC_W/2] == '0));

endmodule

bind tmac_unit tmac_checker u_tmac_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_mode  (in_mode),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_acc  (out_acc)
);

// File: tb/test_tmac_unit.sv
`timescale 1ns/1ps
module test_tmac_unit;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          in_ready;
    logic          in_mode;
    logic [255:0]  in_lhs;
    logic [255:0]  in_rhs;
    logic [1023:0] in_acc;
    logic          out_valid;
    logic          out_ready;
    logic [1023:0] out_acc;

    always #4 clk = ~clk;

    tmac_unit i_tmac_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_mode  (in_mode),
        .in_lhs   (in_lhs),
        .in_rhs   (in_rhs),
        .in_acc   (in_acc),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_acc  (out_acc)
    );

    int  n_tests = 0;
    int  n_fail  = 0;
    int  cyc     = 0;
    bit  stall_mode = 1'b0;
    bit  done = 1'b0;

    logic [255:0]  q_lhs [8];
    logic [255:0]  q_rhs [8];
    logic [1023:0] q_acc [8];
    logic [1023:0] q_exp [8];
    bit            q_has_exp [8];
    logic          q_mode [8];
    int            q_cyc [8];
    bit            q_nostall [8];
    string         q_tag [8];
    int            wr = 0;
    int            rd = 0;

    bit            hold_pending = 1'b0;
    logic [1023:0] hold_val;

    function automatic logic [1023:0] ref_mac(input logic [255:0] l, input logic [255:0] r,
                                              input logic [1023:0] a, input logic m);
        logic [1023:0]      res;
        logic signed [31:0] s32;
        logic signed [63:0] s64;
        res = '0;
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                if (!m) begin
                    s32 = a[32*(4*i+j) +: 32];
                    for (int k = 0; k < 8; k++)
                        s32 = s32 + $signed(l[64*i+8*k +: 8]) * $signed(r[64*j+8*k +: 8]);
                    res[32*(4*i+j) +: 32] = s32;
                end else begin
                    s64 = a[64*(4*i+j) +: 64];
                    for (int k = 0; k < 4; k++)
                        s64 = s64 + $signed(l[64*i+16*k +: 16]) * $signed(r[64*j+16*k +: 16]);
                    res[64*(4*i+j) +: 64] = s64;
                end
            end
        end
        return res;
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int w = 0; w < 8; w++) v[32*w +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [1023:0] rnd1024();
        logic [1023:0] v;
        for (int w = 0; w < 32; w++) v[32*w +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [1023:0] act,
                       input logic [1023:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [255:0] l, input logic [255:0] r,
                        input logic [1023:0] a, input logic m, input string tag,
                        input bit has_exp, input logic [1023:0] exp_in, output bit accepted);
        int            idx;
        logic [1023:0] e;
        @(negedge clk);
        cyc++;
        out_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
        in_valid  = v;
        in_lhs    = l;
        in_rhs    = r;
        in_acc    = a;
        in_mode   = m;
        #1;
        if (hold_pending)
            chk(out_valid && (out_acc == hold_val), "R9 refused result held", out_acc, hold_val);
        hold_pending = out_valid && !out_ready;
        hold_val     = out_acc;
        if (out_valid && !out_ready)
            chk(!in_ready, "R9 in_ready low while stalled", 1024'(in_ready), 1024'(0));
        if (!stall_mode && v)
            chk(in_ready, "R8 accepted every cycle", 1024'(in_ready), 1024'(1));
        if (out_valid && out_ready) begin
            if (rd == wr) begin
                chk(1'b0, "R11 result without operation", out_acc, '0);
            end else begin
                idx = rd % 8;
                e = q_has_exp[idx] ? q_exp[idx] : ref_mac(q_lhs[idx], q_rhs[idx], q_acc[idx], q_mode[idx]);
                chk(out_acc == e, q_tag[idx], out_acc, e);
                if (q_mode[idx] == 1'b0)
                    chk(out_acc[1023:512] == '0, "R6 upper half zero", out_acc, e);
                if (q_nostall[idx] && !stall_mode)
                    chk((cyc - q_cyc[idx]) == 2, "R7 latency", 1024'(cyc - q_cyc[idx]), 1024'(2));
                rd++;
            end
        end
        accepted = v && in_ready;
        if (accepted) begin
            idx = wr % 8;
            q_lhs[idx] = l; q_rhs[idx] = r; q_acc[idx] = a; q_mode[idx] = m;
            q_tag[idx] = tag; q_has_exp[idx] = has_exp; q_exp[idx] = exp_in;
            q_cyc[idx] = cyc; q_nostall[idx] = !stall_mode;
            wr++;
        end
    endtask

    task automatic issue(input logic [255:0] l, input logic [255:0] r, input logic [1023:0] a,
                         input logic m, input string tag);
        bit got;
        do step(1'b1, l, r, a, m, tag, 1'b0, '0, got); while (!got);
    endtask

    task automatic issue_exp(input logic [255:0] l, input logic [255:0] r, input logic [1023:0] a,
                             input logic m, input string tag, input logic [1023:0] e);
        bit got;
        do step(1'b1, l, r, a, m, tag, 1'b1, e, got); while (!got);
    endtask

    task automatic idle(input int n);
        bit got;
        for (int c = 0; c < n; c++)
            step(1'b0, rnd256(), rnd256(), rnd1024(), 1'($urandom), "R11 idle", 1'b0, '0, got);
    endtask

    initial begin
        automatic logic [15:0] corners [8] = '{16'h8000, 16'h8001, 16'hFFFF, 16'h0000,
                                               16'h0001, 16'h7FFF, 16'h1234, 16'hC001};
        logic [255:0]  l;
        logic [255:0]  r;
        logic [1023:0] a;
        logic [1023:0] e;
        logic [7:0]    av;

        rst_n = 1'b0; in_valid = 1'b0; in_mode = 1'b0; out_ready = 1'b0;
        in_lhs = '0; in_rhs = '0; in_acc = '0;
        repeat (3) @(negedge clk);
        chk(!out_valid, "R10 out_valid low in reset", 1024'(out_valid), 1024'(0));
        chk(in_ready, "R10 in_ready high in reset", 1024'(in_ready), 1024'(1));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R10 out_valid low after reset", 1024'(out_valid), 1024'(0));
        chk(in_ready, "R10 in_ready high after reset", 1024'(in_ready), 1024'(1));

        // R5 R2 single-element placement, byte mode: left (2,5)=3, right (1,5)=7 -> lane 9
        l = '0; r = '0; a = '0; e = '0;
        l[64*2 + 8*5 +: 8] = 8'd3;
        r[64*1 + 8*5 +: 8] = 8'd7;
        e[32*9 +: 32] = 32'd21;
        issue_exp(l, r, a, 1'b0, "R5 R2 byte element placement", e);
        // R5 R6 16-bit placement: left (3,1)=-2, right (0,1)=5, acc lane 12=100, lane 5 passes
        l = '0; r = '0; a = '0; e = '0;
        l[64*3 + 16*1 +: 16] = 16'hFFFE;
        r[64*0 + 16*1 +: 16] = 16'd5;
        a[64*12 +: 64] = 64'd100;
        a[64*5 +: 64]  = 64'h1234;
        e[64*12 +: 64] = 64'd90;
        e[64*5 +: 64]  = 64'h1234;
        issue_exp(l, r, a, 1'b1, "R5 R6 half-word placement", e);
        // R4 wrap in byte mode: 8*(-128*-128)=0x20000 onto 0x7FFFFFFF
        l = {32{8'h80}}; r = {32{8'h80}};
        a = '0; e = '0;
        for (int n = 0; n < 16; n++) begin
            a[32*n +: 32] = 32'h7FFF_FFFF;
            e[32*n +: 32] = 32'h8001_FFFF;
        end
        issue_exp(l, r, a, 1'b0, "R4 byte lane wraps", e);
        // R4 wrap in 16-bit mode: 4*2^30 onto max positive
        l = {16{16'h8000}}; r = {16{16'h8000}};
        for (int n = 0; n < 16; n++) begin
            a[64*n +: 64] = 64'h7FFF_FFFF_FFFF_FFFF;
            e[64*n +: 64] = 64'h8000_0000_FFFF_FFFF;
        end
        issue_exp(l, r, a, 1'b1, "R4 half-word lane wraps", e);
        idle(4);

        // R1 R2 exhaustive byte-pair sweep
        for (int ai = -128; ai < 128; ai++) begin
            av = 8'(ai);
            for (int bq = 0; bq < 64; bq++) begin
                l = {32{av}};
                r = '0;
                for (int j = 0; j < 4; j++) r[64*j +: 8] = 8'(bq*4 + j - 128);
                issue(l, r, rnd1024(), 1'b0, "R1 R2 byte pair sweep");
            end
        end
        idle(3);

        // R3 corner pairs
        for (int x = 0; x < 8; x++)
            for (int y = 0; y < 8; y++)
                issue({16{corners[x]}}, {16{corners[y]}}, rnd1024(), 1'b1, "R3 half-word corners");
        idle(3);

        for (int n = 0; n < 300; n++) issue(rnd256(), rnd256(), rnd1024(), 1'b0, "R1 random byte op");
        for (int n = 0; n < 300; n++) issue(rnd256(), rnd256(), rnd1024(), 1'b1, "R3 random half-word op");
        idle(4);

        // R9 R11 mixed modes, gaps and output stalls
        stall_mode = 1'b1;
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 3) == 0) idle(1);
            issue(rnd256(), rnd256(), rnd1024(), 1'($urandom), "R1 R3 mixed stalled op");
        end
        stall_mode = 1'b0;
        idle(6);
        chk(rd == wr, "R11 one result per operation", 1024'(rd), 1024'(wr));
        for (int n = 0; n < 5; n++) begin
            idle(1);
            chk(!out_valid, "R11 no output from idle inputs", 1024'(out_valid), 1024'(0));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule